// File: doc/BRIEF.md
# Load/Store Unit with Console Sink

This unit carries out the memory half of integer load and store instructions for a single-issue core. Each request carries a base register value, a 12-bit signed offset, the three-bit access-type field, the store data, and a flag that says the load's destination is the zero register. The unit forms the effective address and splits the address space on its top bit. The lower half is byte-addressed little-endian RAM, reached through a synchronous port with byte enables. The upper half is an I/O region.

In the I/O region, a store to exactly `0x8000_0000` pushes its bytes, lowest first, out of a valid/ready byte stream that feeds a console. The unit raises `busy` until the last byte is taken. Other stores into the region vanish, and every load from it returns zero. A request with the reserved size code does nothing except raise a one-cycle error pulse.

Top module: `lsu_console`

## Requirements
- R1: `ramAddr` equals `reqBase` plus the sign-extended `reqOffset`, wrapping modulo 2^32, in the same cycle as the request.
- R2: `reqFunct3[1:0]` selects the size: 0 byte, 1 halfword, 2 word. `ramBe` is 4'b0001, 4'b0011 or 4'b1111 shifted left by `ramAddr[1:0]`. `ramWdata` carries the byte or halfword repeated across all four lanes, or the whole word.
- R3: A load result appears on `loadData` with `loadValid` one cycle after acceptance. It takes the lanes selected by the address, little-endian. Bytes and halfwords are sign-extended when `reqFunct3[2]` is 0 and zero-extended when it is 1.
- R4: `ramReq` is raised only for addresses with bit 31 clear. Every accepted load or store of legal size below that boundary raises it.
- R5: A store to `0x8000_0000` presents 1, 2 or 4 bytes on `conData`/`conValid`, in ascending byte order. Each byte is held stable until `conReady`. `busy` stays high until the last byte is accepted.
- R6: A store to any other address with bit 31 set causes neither a RAM access nor console output.
- R7: A load from an address with bit 31 set returns zero on `loadData` one cycle later.
- R8: With `reqRdZero` set, a load still returns `loadValid`, but `loadWe` stays low. Otherwise `loadWe` follows `loadValid`.
- R9: While `busy` is high, `reqValid` is ignored: no RAM access, and no later effect.
- R10: Size code 3 gives `err` high for exactly the next cycle, with no RAM access, no console output and no `loadValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqFunct3 | input | 3 | Access type: size in [1:0], unsigned in [2] |
| reqBase | input | 32 | Base register value |
| reqOffset | input | 12 | Signed immediate offset |
| reqStoreData | input | 32 | Store data |
| reqRdZero | input | 1 | Load destination is the zero register |
| busy | output | 1 | Console drain in progress; requests ignored |
| ramReq | output | 1 | RAM access strobe |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 32 | Effective byte address |
| ramBe | output | 4 | Byte-lane enables |
| ramWdata | output | 32 | Lane-replicated store data |
| ramRdata | input | 32 | Read word, one cycle after ramReq |
| loadValid | output | 1 | Load result valid |
| loadData | output | 32 | Extended load result |
| loadWe | output | 1 | Write the result back to the register file |
| err | output | 1 | Illegal-size pulse |
| conValid | output | 1 | Console byte valid |
| conData | output | 8 | Console byte |
| conReady | input | 1 | Console accepts byte |

## Verification
The RAM-side outputs (`ramReq`, `ramAddr`, `ramBe`, `ramWe`, `ramWdata`) are combinational from the request, so the driver checks them 1 ns after it drives the request, before the accepting edge. The load result and `err` are registered behind that edge, so they are sampled at the following falling edge. A scoreboard queue pairs each `loadValid` with the value predicted from a separate byte image of memory. A second queue holds the expected console bytes. Those bytes are compared at each falling edge where `conValid` and the bench-driven `conReady` are both high, since that is the handshake the next rising edge completes.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned LANES   = WORD_W / LANE_W;
  localparam int unsigned LANE_IW = $clog2(LANES);
  localparam int unsigned CNT_W   = $clog2(LANES) + 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_t;

  typedef struct packed {
    logic ramReq;
    logic ramWe;
    logic loadLaunch;
    logic errSet;
    logic conLoad;
    logic conAdvance;
  } lsuStrobe_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqStore,
  input  logic       sizeBad,
  input  logic       isIo,
  input  logic       isConsole,
  input  logic       conLast,
  input  logic       conReady,
  output lsuStrobe_t strobe,
  output logic       busy,
  output logic       conValid
);
  typedef enum logic {ST_IDLE, ST_DRAIN} ctrlState_t;
  ctrlState_t state, stateNext;
  logic accept;

  assign accept   = reqValid && (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign conValid = (state == ST_DRAIN);

  always_comb begin
    strobe = '0;
    if (accept) begin
      if (sizeBad) begin
        strobe.errSet = 1'b1;
      end else if (!reqStore) begin
        strobe.loadLaunch = 1'b1;
        strobe.ramReq     = !isIo;
      end else if (!isIo) begin
        strobe.ramReq = 1'b1;
        strobe.ramWe  = 1'b1;
      end else if (isConsole) begin
        strobe.conLoad = 1'b1;
      end
    end
    if (state == ST_DRAIN && conReady) strobe.conAdvance = 1'b1;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobe.conLoad) stateNext = ST_DRAIN;
      ST_DRAIN: if (conReady && conLast) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/lsu_dpath.sv
module lsu_dpath
  import lsu_pkg::*;
#(
  parameter int unsigned       OFF_W        = 12,
  parameter logic [WORD_W-1:0] CONSOLE_ADDR = 32'h8000_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WORD_W-1:0]   reqBase,
  input  logic [OFF_W-1:0]    reqOffset,
  input  logic [2:0]          reqFunct3,
  input  logic [WORD_W-1:0]   reqStoreData,
  input  logic                reqRdZero,
  input  lsuStrobe_t          strobe,
  output logic                sizeBad,
  output logic                isIo,
  output logic                isConsole,
  output logic                conLast,
  output logic [WORD_W-1:0]   ramAddr,
  output logic [LANES-1:0]    ramBe,
  output logic [WORD_W-1:0]   ramWdata,
  input  logic [WORD_W-1:0]   ramRdata,
  output logic                loadValid,
  output logic [WORD_W-1:0]   loadData,
  output logic                loadWe,
  output logic                err,
  output logic [LANE_W-1:0]   conData
);
  localparam int unsigned EXT_W = WORD_W - OFF_W;
  localparam int unsigned HALF_W = 2 * LANE_W;

  accSize_t             reqSize;
  logic [WORD_W-1:0]    effAddr;
  logic [LANE_IW-1:0]   laneOff;
  logic [LANES-1:0]     baseMask;
  logic [CNT_W-1:0]     sizeBytes;

  assign reqSize   = accSize_t'(reqFunct3[1:0]);
  assign effAddr   = reqBase + {{EXT_W{reqOffset[OFF_W-1]}}, reqOffset};
  assign laneOff   = effAddr[LANE_IW-1:0];
  assign sizeBad   = (reqSize == SZ_BAD);
  assign isIo      = effAddr[WORD_W-1];
  assign isConsole = (effAddr == CONSOLE_ADDR);
  assign ramAddr   = effAddr;

  always_comb begin
    unique case (reqSize)
      SZ_BYTE: begin baseMask = LANES'(1);            sizeBytes = CNT_W'(1); end
      SZ_HALF: begin baseMask = LANES'(3);            sizeBytes = CNT_W'(2); end
      SZ_WORD: begin baseMask = {LANES{1'b1}};        sizeBytes = CNT_W'(LANES); end
      default: begin baseMask = '0;                   sizeBytes = '0; end
    endcase
  end

  assign ramBe = strobe.ramReq ? (baseMask << laneOff) : '0;

  // Lane replication of store data.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      unique case (reqSize)
        SZ_BYTE: ramWdata[k*LANE_W +: LANE_W] = reqStoreData[LANE_W-1:0];
        SZ_HALF: ramWdata[k*LANE_W +: LANE_W] = reqStoreData[(k%2)*LANE_W +: LANE_W];
        default: ramWdata[k*LANE_W +: LANE_W] = reqStoreData[k*LANE_W +: LANE_W];
      endcase
    end
  end

  // Load return pipeline.
  logic               ldPend, ldIo, ldUnsigned, ldRdZero, errReg;
  accSize_t           ldSize;
  logic [LANE_IW-1:0] ldLane;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldPend     <= 1'b0;
      ldIo       <= 1'b0;
      ldUnsigned <= 1'b0;
      ldRdZero   <= 1'b0;
      ldSize     <= SZ_WORD;
      ldLane     <= '0;
      errReg     <= 1'b0;
    end else begin
      ldPend <= strobe.loadLaunch;
      errReg <= strobe.errSet;
      if (strobe.loadLaunch) begin
        ldIo       <= isIo;
        ldUnsigned <= reqFunct3[2];
        ldRdZero   <= reqRdZero;
        ldSize     <= reqSize;
        ldLane     <= laneOff;
      end
    end
  end

  logic [WORD_W-1:0] ldShifted, ldExt;
  assign ldShifted = ramRdata >> {ldLane, 3'b000};

  always_comb begin
    unique case (ldSize)
      SZ_BYTE: ldExt = ldUnsigned
        ? {{(WORD_W-LANE_W){1'b0}}, ldShifted[LANE_W-1:0]}
        : {{(WORD_W-LANE_W){ldShifted[LANE_W-1]}}, ldShifted[LANE_W-1:0]};
      SZ_HALF: ldExt = ldUnsigned
        ? {{(WORD_W-HALF_W){1'b0}}, ldShifted[HALF_W-1:0]}
        : {{(WORD_W-HALF_W){ldShifted[HALF_W-1]}}, ldShifted[HALF_W-1:0]};
      default: ldExt = ldShifted;
    endcase
  end

  assign loadValid = ldPend;
  assign loadData  = (ldPend && !ldIo) ? ldExt : '0;
  assign loadWe    = ldPend && !ldRdZero;
  assign err       = errReg;

  // Console byte shifter.
  logic [WORD_W-1:0] conBuf;
  logic [CNT_W-1:0]  conLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      conBuf  <= '0;
      conLeft <= '0;
    end else if (strobe.conLoad) begin
      conBuf  <= reqStoreData;
      conLeft <= sizeBytes;
    end else if (strobe.conAdvance) begin
      conBuf  <= conBuf >> LANE_W;
      conLeft <= conLeft - CNT_W'(1);
    end
  end

  assign conData = conBuf[LANE_W-1:0];
  assign conLast = (conLeft == CNT_W'(1));
endmodule

// File: rtl/lsu_console.sv
module lsu_console
  import lsu_pkg::*;
#(
  parameter int unsigned       OFF_W        = 12,
  parameter logic [WORD_W-1:0] CONSOLE_ADDR = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [2:0]        reqFunct3,
  input  logic [WORD_W-1:0] reqBase,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [WORD_W-1:0] reqStoreData,
  input  logic              reqRdZero,
  output logic              busy,
  output logic              ramReq,
  output logic              ramWe,
  output logic [WORD_W-1:0] ramAddr,
  output logic [LANES-1:0]  ramBe,
  output logic [WORD_W-1:0] ramWdata,
  input  logic [WORD_W-1:0] ramRdata,
  output logic              loadValid,
  output logic [WORD_W-1:0] loadData,
  output logic              loadWe,
  output logic              err,
  output logic              conValid,
  output logic [LANE_W-1:0] conData,
  input  logic              conReady
);
  lsuStrobe_t strobe;
  logic sizeBad, isIo, isConsole, conLast;

  lsu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .sizeBad(sizeBad), .isIo(isIo), .isConsole(isConsole), .conLast(conLast),
    .conReady(conReady), .strobe(strobe), .busy(busy), .conValid(conValid)
  );

  lsu_dpath #(.OFF_W(OFF_W), .CONSOLE_ADDR(CONSOLE_ADDR)) u_dpath (
    .clk(clk), .rstN(rstN), .reqBase(reqBase), .reqOffset(reqOffset),
    .reqFunct3(reqFunct3), .reqStoreData(reqStoreData), .reqRdZero(reqRdZero),
    .strobe(strobe), .sizeBad(sizeBad), .isIo(isIo), .isConsole(isConsole),
    .conLast(conLast), .ramAddr(ramAddr), .ramBe(ramBe), .ramWdata(ramWdata),
    .ramRdata(ramRdata), .loadValid(loadValid), .loadData(loadData),
    .loadWe(loadWe), .err(err), .conData(conData)
  );

  assign ramReq = strobe.ramReq;
  assign ramWe  = strobe.ramWe;
endmodule

// File: rtl/lsu_console_chk.sv
module lsu_console_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [2:0]  reqFunct3,
  input logic        busy,
  input logic        ramReq,
  input logic [31:0] ramAddr,
  input logic [3:0]  ramBe,
  input logic        loadValid,
  input logic        loadWe,
  input logic        err,
  input logic        conValid,
  input logic [7:0]  conData,
  input logic        conReady
);
  a_r4_ram_low_only: assert property (@(posedge clk) disable iff (!rstN)
    ramReq |-> !ramAddr[31]);
  a_r2_lanes_present: assert property (@(posedge clk) disable iff (!rstN)
    ramReq |-> (ramBe != 4'b0000));
  a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ramReq);
  a_r5_con_hold: assert property (@(posedge clk) disable iff (!rstN)
    (conValid && !conReady) |=> (conValid && $stable(conData)));
  a_r5_con_busy: assert property (@(posedge clk) disable iff (!rstN)
    conValid |-> busy);
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqFunct3[1:0] == 2'b11) |-> !ramReq);
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqFunct3[1:0] == 2'b11) |=> (err && !loadValid));
  a_r8_we_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    loadWe |-> loadValid);
endmodule

bind lsu_console lsu_console_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFunct3(reqFunct3),
  .busy(busy), .ramReq(ramReq), .ramAddr(ramAddr), .ramBe(ramBe),
  .loadValid(loadValid), .loadWe(loadWe), .err(err), .conValid(conValid),
  .conData(conData), .conReady(conReady)
);

// File: tb/test_lsu_console.sv
`timescale 1ns/1ps
module test_lsu_console;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqStore = 0, reqRdZero = 0;
  logic [2:0] reqFunct3 = 0;
  logic [31:0] reqBase = 0, reqStoreData = 0;
  logic [11:0] reqOffset = 0;
  logic busy, ramReq, ramWe, loadValid, loadWe, err, conValid;
  logic conReady = 1'b1;
  logic [31:0] ramAddr, ramWdata, loadData;
  logic [31:0] ramRdata = 0;
  logic [3:0] ramBe;
  logic [7:0] conData;

  always #4 clk = ~clk;

  lsu_console i_lsu_console (.*);

  int tests = 0, fails = 0;
  int readyMode = 0;
  bit started = 0, toggler = 0;
  logic [7:0] benchRam [64];
  logic [7:0] refMem [64];
  logic [32:0] expLoad [$];
  logic [7:0] expCon [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench RAM: synchronous read, byte-enabled write.
  always @(posedge clk) begin
    if (ramReq && ramWe) begin
      for (int k = 0; k < 4; k++)
        if (ramBe[k]) benchRam[{ramAddr[5:2], 2'(k)}] = ramWdata[k*8 +: 8];
    end else if (ramReq) begin
      ramRdata <= {benchRam[{ramAddr[5:2], 2'd3}], benchRam[{ramAddr[5:2], 2'd2}],
                   benchRam[{ramAddr[5:2], 2'd1}], benchRam[{ramAddr[5:2], 2'd0}]};
    end
  end

  function automatic logic [31:0] refLoad(input logic [31:0] a, input logic [2:0] f3);
    logic [31:0] w;
    w = {refMem[(a+3)&63], refMem[(a+2)&63], refMem[(a+1)&63], refMem[a&63]};
    case (f3)
      3'd0: return {{24{w[7]}}, w[7:0]};
      3'd1: return {{16{w[15]}}, w[15:0]};
      3'd4: return {24'b0, w[7:0]};
      3'd5: return {16'b0, w[15:0]};
      default: return w;
    endcase
  endfunction

  task automatic issue(input logic st, input logic [2:0] f3, input logic [31:0] base,
                       input logic [11:0] off, input logic [31:0] sd, input logic rz);
    logic [31:0] a, rep;
    logic [3:0] m;
    logic expReq;
    int n;
    while (busy) @(negedge clk);
    reqValid = 1; reqStore = st; reqFunct3 = f3; reqBase = base;
    reqOffset = off; reqStoreData = sd; reqRdZero = rz;
    #1;
    a = base + {{20{off[11]}}, off};
    n = (f3[1:0] == 0) ? 1 : (f3[1:0] == 1) ? 2 : 4;
    check(ramAddr == a, "R1 address", ramAddr, a);
    expReq = (f3[1:0] != 2'd3) && !a[31];
    check(ramReq == expReq, a[31] ? "R4/R6 io no ram" : "R4/R10 ram strobe", {31'b0, ramReq}, {31'b0, expReq});
    if (expReq) begin
      m = (f3[1:0] == 0) ? 4'b0001 : (f3[1:0] == 1) ? 4'b0011 : 4'b1111;
      m = m << a[1:0];
      check(ramBe == m, "R2 byte enables", {28'b0, ramBe}, {28'b0, m});
      check(ramWe == st, "R2 write enable", {31'b0, ramWe}, {31'b0, st});
      if (st) begin
        rep = (n == 1) ? {4{sd[7:0]}} : (n == 2) ? {2{sd[15:0]}} : sd;
        check(ramWdata == rep, "R2 lane replication", ramWdata, rep);
      end
    end
    if (f3[1:0] != 2'd3) begin
      if (!st) expLoad.push_back({!rz, a[31] ? 32'h0 : refLoad(a, f3)});
      else if (!a[31]) for (int i = 0; i < n; i++) refMem[(a+i)&63] = sd[i*8 +: 8];
      else if (a == 32'h8000_0000) for (int i = 0; i < n; i++) expCon.push_back(sd[i*8 +: 8]);
    end
    @(negedge clk);
    reqValid = 0;
    check(err == (f3[1:0] == 2'd3), "R10 error pulse", {31'b0, err}, {31'b0, f3[1:0] == 2'd3});
  endtask

  // Monitor: scoreboard pops at falling edges.
  always @(negedge clk) begin
    if (started) begin
      toggler = ~toggler;
      conReady = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? toggler : 1'b0;
      if (loadValid) begin
        if (expLoad.size() == 0) check(0, "R3/R10 unexpected loadValid", loadData, 0);
        else begin
          logic [32:0] e;
          e = expLoad.pop_front();
          check(loadData == e[31:0], "R3/R7 load data", loadData, e[31:0]);
          check(loadWe == e[32], "R8 write-back", {31'b0, loadWe}, {31'b0, e[32]});
        end
      end
      if (conValid && conReady) begin
        if (expCon.size() == 0) check(0, "R5/R6 unexpected console byte", {24'b0, conData}, 0);
        else begin
          logic [7:0] c;
          c = expCon.pop_front();
          check(conData == c, "R5 console byte", {24'b0, conData}, {24'b0, c});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin benchRam[i] = 8'h00; refMem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    check(!busy && !conValid && !loadValid && !err && !ramReq, "reset state", {27'b0, busy, conValid, loadValid, err, ramReq}, 0);
    rstN = 1;
    @(negedge clk);
    started = 1;
    // R1 wrap into the I/O region, store discarded (R6)
    issue(1, 3'd2, 32'h0000_0004, 12'hFF8, 32'h1111_1111, 0);
    // RAM stores, R2
    issue(1, 3'd2, 32'h0000_0020, 12'hFF0, 32'h8899_AABB, 0);
    issue(1, 3'd0, 32'h0000_0013, 12'h000, 32'hFFFF_FF5A, 0);
    issue(1, 3'd1, 32'h0000_0010, 12'h006, 32'h0000_1234, 0);
    issue(1, 3'd0, 32'h0000_0011, 12'h000, 32'h0000_0080, 0);
    issue(1, 3'd1, 32'h0000_0018, 12'h000, 32'h0000_F00D, 0);
    // R3 loads with sign/zero extension
    issue(0, 3'd0, 32'h0000_0013, 12'h000, 0, 0);
    issue(0, 3'd0, 32'h0000_0011, 12'h000, 0, 0);
    issue(0, 3'd4, 32'h0000_0011, 12'h000, 0, 0);
    issue(0, 3'd1, 32'h0000_0016, 12'h000, 0, 0);
    issue(0, 3'd1, 32'h0000_0018, 12'h000, 0, 0);
    issue(0, 3'd5, 32'h0000_0018, 12'h000, 0, 0);
    issue(0, 3'd2, 32'h0000_0010, 12'h000, 0, 0);
    // R8 destination zero
    issue(0, 3'd2, 32'h0000_0010, 12'h000, 0, 1);
    // R7 I/O loads
    issue(0, 3'd2, 32'h8000_0010, 12'h000, 0, 0);
    issue(0, 3'd4, 32'h8000_0000, 12'h000, 0, 0);
    // R5 console stores
    issue(1, 3'd0, 32'h8000_0000, 12'h000, 32'h0000_0041, 0);
    readyMode = 1;
    issue(1, 3'd1, 32'h8000_0010, 12'hFF0, 32'h0000_4342, 0);
    issue(1, 3'd2, 32'h8000_0000, 12'h000, 32'h4746_4544, 0);
    // R6 other I/O store
    issue(1, 3'd2, 32'h8000_0004, 12'h000, 32'h5555_5555, 0);
    // R10 illegal size, store and load
    issue(1, 3'd3, 32'h0000_0020, 12'h000, 32'hCAFE_CAFE, 0);
    issue(0, 3'd3, 32'h0000_0020, 12'h000, 0, 0);
    issue(0, 3'd2, 32'h0000_0020, 12'h000, 0, 0);
    // R9 requests ignored while busy
    while (busy) @(negedge clk);
    readyMode = 2;
    issue(1, 3'd2, 32'h8000_0000, 12'h000, 32'h4B4A_4948, 0);
    check(busy, "R5 busy during drain", {31'b0, busy}, 1);
    reqValid = 1; reqStore = 1; reqFunct3 = 3'd2; reqBase = 32'h24;
    reqOffset = 0; reqStoreData = 32'hDEAD_BEEF;
    #1;
    check(!ramReq, "R9 ignored while busy", {31'b0, ramReq}, 0);
    @(negedge clk);
    reqValid = 0;
    check(conValid && conData == 8'h48, "R5 byte held while not ready", {24'b0, conData}, 32'h48);
    readyMode = 0;
    issue(0, 3'd2, 32'h0000_0024, 12'h000, 0, 0);
    repeat (4) @(negedge clk);
    check(expLoad.size() == 0, "R3 all loads returned", expLoad.size(), 0);
    check(expCon.size() == 0, "R5 all console bytes seen", expCon.size(), 0);
    check(!busy, "R5 busy released", {31'b0, busy}, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule